// File: doc/BRIEF.md
# Receive Buffer Descriptor Queue Manager

This block sits in an Ethernet-style receive DMA path. It walks a circular list of receive buffer descriptors in memory. Each descriptor is two 32-bit words. The block reads the first word of the current entry and checks its ownership flag. If the entry is free, it hands the buffer address to the receive datapath. When a buffer has been filled, the block writes the descriptor back as a two-word pair. The first word gets its ownership flag set. The second word records whether the buffer opens and/or closes a frame.

Software loads the list base while reception is disabled, then enables reception. A frame is taken only when the address filter accepts it. A frame may span several buffers, and each filled buffer asks for a fresh descriptor.

When a fetched descriptor is still owned by software, the block raises a sticky status flag and an interrupt pulse. If a frame was in progress at that moment, the frame is also dropped and a saturating, clear-on-read resource error counter is incremented. On a frame error, only the buffer being filled is given back: the queue pointer stays on its entry, and the entry's ownership flag is left clear.

Top module: `rx_desc_queue`

## Requirements
- R1: A write on `ptrWr` while `rxEn` is 0 loads the list base with bits [2:0] forced to 0 and sets `qPtr` to that base. A write while `rxEn` is 1 is ignored.
- R2: While enabled and holding no descriptor, the block reads word 0 at `qPtr`. If bit 0 of that word is 0, it raises `bufValid` and drives `bufAddr` with bits [31:2] of the word and bits [1:0] at 0.
- R3: `frmStart` with `addrAccept`=1 while a buffer is held starts a frame. With `addrAccept`=0 the pulse is ignored: no memory write, and `qPtr` is unchanged.
- R4: When a buffer completes (`bufFull` or `frmEnd`), the block writes word 0 at `qPtr` with bit 0 set and the other bits unchanged. In the next cycle it writes word 1 at `qPtr`+4 with bit 0 = start of frame (first buffer of the frame), bit 1 = end of frame (buffer closed by `frmEnd`), and the other bits 0.
- R5: After the write-back, `qPtr` moves to the next entry (+8). It returns to the base instead if bit 1 (wrap) of the entry's word 0 is set, or if the entry index is MAX_ENTRIES-1 (1023 by default).
- R6: `frmErr` during a frame writes nothing for the current buffer. `qPtr` stays on that entry, and the same entry is fetched again. Buffers already written for that frame keep their ownership flag set.
- R7: A fetch that finds bit 0 = 1 presents no buffer, sets the sticky `bnaFlag` and pulses `irq` for one cycle. `bnaClr` clears `bnaFlag`.
- R8: After such a fetch, `frmStart` with `addrAccept`=1 fetches the same entry again. If the entry is still owned, or if an owned entry is met while fetching the next buffer of a frame, the frame is dropped: `frameDrop` pulses and `errCnt` increments. If the entry is free, the frame proceeds into it.
- R9: `errCnt` stops at its maximum value (255 by default), and `errCntRd` clears it to 0.
- R10: No memory access starts while `rxEn` is 0 and no transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEn | input | 1 | Receive enable |
| ptrWr | input | 1 | Write strobe for the list base |
| ptrWrData | input | 32 | List base value |
| bnaClr | input | 1 | Clears the buffer-not-available flag |
| errCntRd | input | 1 | Read strobe that clears the error counter |
| frmStart | input | 1 | Frame start pulse from the receive datapath |
| addrAccept | input | 1 | Address filter verdict, sampled with frmStart |
| bufFull | input | 1 | Current buffer filled, frame continues |
| frmEnd | input | 1 | Frame ended in the current buffer |
| frmErr | input | 1 | Frame error during the current buffer |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request accepted |
| qPtr | output | 32 | Address of the entry currently accessed |
| bufValid | output | 1 | A free buffer is held |
| bufAddr | output | 32 | Address of the held buffer |
| bnaFlag | output | 1 | Sticky buffer-not-available flag |
| irq | output | 1 | One-cycle interrupt pulse on buffer-not-available |
| frameDrop | output | 1 | One-cycle pulse when a frame is dropped |
| errCnt | output | 8 | Receive resource error count |

## Verification
The descriptor walk is tried with several kinds of traffic:
- **Frame sizes:** single-buffer frames and a three-buffer frame. Between them they separate the start-of-frame and end-of-frame coding in word 1.
- **End of list:** a list ended by a wrap flag and a list ended only by the 1024-entry limit. These two tell the wrap-flag return from the hard-count return.
- **Owned entries:** an owned entry met during an idle prefetch, on a retry, and while fetching the next buffer of a frame. These separate a status-only report from a frame drop.
- **Other patterns:** a frame error after one finished buffer shows that only the current buffer is given back. Long runs of retries drive the error counter into saturation.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_HOLD,
    S_FILL,
    S_WR0,
    S_WR1,
    S_STALL
  } rxqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldBase;   // load list base, index to 0
    logic ldDesc;   // capture fetched word 0
    logic advance;  // step or wrap the entry index
    logic selWr1;   // second word of write-back pair
    logic sofBit;   // start-of-frame flag for word 1
    logic eofBit;   // end-of-frame flag for word 1
    logic setBna;   // owned descriptor seen
    logic bumpErr;  // frame dropped for lack of buffer
  } rxqStrobe_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEn,
  input  logic       ptrWr,
  input  logic       frmStart,
  input  logic       addrAccept,
  input  logic       bufFull,
  input  logic       frmEnd,
  input  logic       frmErr,
  input  logic       memAck,
  input  logic       rdUsed,
  output logic       memReq,
  output logic       memWe,
  output logic       bufValid,
  output rxqStrobe_t st
);

  rxqState_e state, stateNxt;
  logic inFrame, inFrameNxt;
  logic firstBuf, firstBufNxt;
  logic eofPend, eofPendNxt;
  logic acceptFrm, cfgOk;

  assign acceptFrm = frmStart && addrAccept && rxEn;
  assign cfgOk     = ptrWr && !rxEn;

  always_comb begin
    stateNxt    = state;
    inFrameNxt  = inFrame;
    firstBufNxt = firstBuf;
    eofPendNxt  = eofPend;
    st          = '0;
    st.sofBit   = firstBuf;
    st.eofBit   = eofPend;
    st.selWr1   = (state == S_WR1);
    unique case (state)
      S_IDLE: begin
        if (cfgOk) st.ldBase = 1'b1;
        else if (rxEn) stateNxt = S_RD;
      end
      S_RD: begin
        if (memAck) begin
          if (rdUsed) begin
            st.setBna = 1'b1;
            if (inFrame) begin
              st.bumpErr = 1'b1;
              inFrameNxt = 1'b0;
            end
            stateNxt = S_STALL;
          end else begin
            st.ldDesc = 1'b1;
            stateNxt  = inFrame ? S_FILL : S_HOLD;
          end
        end
      end
      S_HOLD: begin
        if (cfgOk) begin
          st.ldBase = 1'b1;
          stateNxt  = S_IDLE;
        end else if (acceptFrm) begin
          inFrameNxt  = 1'b1;
          firstBufNxt = 1'b1;
          stateNxt    = S_FILL;
        end
      end
      S_FILL: begin
        if (frmErr) begin
          inFrameNxt = 1'b0;
          stateNxt   = S_IDLE;
        end else if (frmEnd) begin
          eofPendNxt = 1'b1;
          stateNxt   = S_WR0;
        end else if (bufFull) begin
          eofPendNxt = 1'b0;
          stateNxt   = S_WR0;
        end
      end
      S_WR0: begin
        if (memAck) stateNxt = S_WR1;
      end
      S_WR1: begin
        if (memAck) begin
          st.advance  = 1'b1;
          firstBufNxt = 1'b0;
          if (eofPend) begin
            inFrameNxt = 1'b0;
            stateNxt   = S_IDLE;
          end else begin
            stateNxt = S_RD;
          end
        end
      end
      S_STALL: begin
        if (cfgOk) begin
          st.ldBase = 1'b1;
          stateNxt  = S_IDLE;
        end else if (acceptFrm) begin
          inFrameNxt  = 1'b1;
          firstBufNxt = 1'b1;
          stateNxt    = S_RD;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      inFrame  <= 1'b0;
      firstBuf <= 1'b0;
      eofPend  <= 1'b0;
    end else begin
      state    <= stateNxt;
      inFrame  <= inFrameNxt;
      firstBuf <= firstBufNxt;
      eofPend  <= eofPendNxt;
    end
  end

  assign memReq   = (state == S_RD) || (state == S_WR0) || (state == S_WR1);
  assign memWe    = (state == S_WR0) || (state == S_WR1);
  assign bufValid = (state == S_HOLD) || (state == S_FILL);

  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && frmStart && !addrAccept && !ptrWr) |=> (state == S_HOLD && !memReq)); // R3
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WR0 && memAck) |=> (memReq && memWe)); // R4
  AST_NO_FETCH_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !rxEn) |=> !memReq); // R10
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && frmErr) |=> (!memWe && !bufValid)); // R6

endmodule

// File: rtl/rxq_dpath.sv
module rxq_dpath
  import rxq_pkg::*;
#(
  parameter int MAX_ENTRIES = 1024,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       st,
  input  logic [31:0]      ptrWrData,
  input  logic [31:0]      memRdata,
  input  logic             bnaClr,
  input  logic             errCntRd,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  output logic [31:0]      qPtr,
  output logic [31:0]      bufAddr,
  output logic             bnaFlag,
  output logic             irq,
  output logic             frameDrop,
  output logic [CNT_W-1:0] errCnt
);

  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int PAD_W = 32 - IDX_W - 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ENTRIES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [31:0]      baseReg;
  logic [IDX_W-1:0] idx;
  logic [31:0]      descReg;
  logic             lastEntry;
  logic [CNT_W-1:0] cntBase;
  logic [CNT_W-1:0] cntNxt;

  // Entry is last when its wrap flag is set or the hard limit is reached
  assign lastEntry = descReg[1] || (idx == LAST_IDX);
  assign qPtr      = baseReg + {{PAD_W{1'b0}}, idx, 3'b000};
  assign memAddr   = st.selWr1 ? (qPtr + 32'd4) : qPtr;
  assign memWdata  = st.selWr1 ? {30'd0, st.eofBit, st.sofBit}
                               : {descReg[31:1], 1'b1};
  assign bufAddr   = {descReg[31:2], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      idx     <= '0;
    end else if (st.ldBase) begin
      baseReg <= {ptrWrData[31:3], 3'b000};
      idx     <= '0;
    end else if (st.advance) begin
      idx <= lastEntry ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) descReg <= '0;
    else if (st.ldDesc) descReg <= memRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bnaFlag   <= 1'b0;
      irq       <= 1'b0;
      frameDrop <= 1'b0;
    end else begin
      if (st.setBna) bnaFlag <= 1'b1;
      else if (bnaClr) bnaFlag <= 1'b0;
      irq       <= st.setBna;
      frameDrop <= st.bumpErr;
    end
  end

  always_comb begin
    cntBase = errCntRd ? '0 : errCnt;
    cntNxt  = cntBase;
    if (st.bumpErr && cntBase != CNT_MAX) cntNxt = cntBase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errCnt <= '0;
    else errCnt <= cntNxt;
  end

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    qPtr[2:0] == 3'b000); // R1
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.ldBase && !lastEntry) |=> qPtr == $past(qPtr) + 32'd8); // R5
  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.ldBase && lastEntry) |=> qPtr == baseReg); // R5
  AST_BNA_SET: assert property (@(posedge clk) disable iff (!rstN)
    st.setBna |=> (bnaFlag && irq)); // R7
  AST_BNA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (bnaFlag && !bnaClr) |=> bnaFlag); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.bumpErr && !errCntRd && errCnt != CNT_MAX) |=> errCnt == $past(errCnt) + 1'b1); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == CNT_MAX && !errCntRd) |=> errCnt == CNT_MAX); // R9

endmodule

// File: rtl/rx_desc_queue.sv
module rx_desc_queue
  import rxq_pkg::*;
#(
  parameter int MAX_ENTRIES = 1024,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEn,
  input  logic             ptrWr,
  input  logic [31:0]      ptrWrData,
  input  logic             bnaClr,
  input  logic             errCntRd,
  input  logic             frmStart,
  input  logic             addrAccept,
  input  logic             bufFull,
  input  logic             frmEnd,
  input  logic             frmErr,
  output logic             memReq,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  input  logic             memAck,
  output logic [31:0]      qPtr,
  output logic             bufValid,
  output logic [31:0]      bufAddr,
  output logic             bnaFlag,
  output logic             irq,
  output logic             frameDrop,
  output logic [CNT_W-1:0] errCnt
);

  rxqStrobe_t st;

  rxq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEn      (rxEn),
    .ptrWr     (ptrWr),
    .frmStart  (frmStart),
    .addrAccept(addrAccept),
    .bufFull   (bufFull),
    .frmEnd    (frmEnd),
    .frmErr    (frmErr),
    .memAck    (memAck),
    .rdUsed    (memRdata[0]),
    .memReq    (memReq),
    .memWe     (memWe),
    .bufValid  (bufValid),
    .st        (st)
  );

  rxq_dpath #(
    .MAX_ENTRIES(MAX_ENTRIES),
    .CNT_W      (CNT_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .ptrWrData (ptrWrData),
    .memRdata  (memRdata),
    .bnaClr    (bnaClr),
    .errCntRd  (errCntRd),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .qPtr      (qPtr),
    .bufAddr   (bufAddr),
    .bnaFlag   (bnaFlag),
    .irq       (irq),
    .frameDrop (frameDrop),
    .errCnt    (errCnt)
  );

endmodule

// File: tb/tb_rx_desc_queue.sv
module tb_rx_desc_queue;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, rxEn, ptrWr, bnaClr, errCntRd;
  logic frmStart, addrAccept, bufFull, frmEnd, frmErr;
  logic [31:0] ptrWrData;
  logic memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [31:0] qPtr, bufAddr;
  logic bufValid, bnaFlag, irq, frameDrop;
  logic [7:0] errCnt;

  rx_desc_queue dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .ptrWr(ptrWr), .ptrWrData(ptrWrData),
    .bnaClr(bnaClr), .errCntRd(errCntRd), .frmStart(frmStart), .addrAccept(addrAccept),
    .bufFull(bufFull), .frmEnd(frmEnd), .frmErr(frmErr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .qPtr(qPtr), .bufValid(bufValid), .bufAddr(bufAddr), .bnaFlag(bnaFlag), .irq(irq),
    .frameDrop(frameDrop), .errCnt(errCnt)
  );

  // Behavioural memory, single-cycle acknowledge
  logic [31:0] mem [0:4095];
  assign memRdata = mem[memAddr[13:2]];
  assign memAck   = memReq;
  always @(posedge clk) if (memReq && memWe) mem[memAddr[13:2]] <= memWdata;

  // Reference model: expected transaction queues and queue position
  logic [31:0] rdQ[$];
  logic [63:0] wrQ[$];
  logic [31:0] mBase;
  int mIdx;
  int compared = 0, mismatched = 0, irqSeen = 0, dropSeen = 0;
  bit done = 0;
  logic [63:0] eW;
  logic [31:0] eR;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wi(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  function automatic logic [31:0] mPtr();
    return mBase + 32'(mIdx * 8);
  endfunction

  function automatic logic [31:0] bufA(input int i);
    return 32'h8000_0000 + 32'(i * 32'h600);
  endfunction

  // Compare every memory transaction as it happens
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (irq) irqSeen++;
      if (frameDrop) dropSeen++;
      if (memReq) begin
        if (memWe) begin
          if (wrQ.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R4 unexpected write actual=%h expected=none", memAddr);
          end else begin
            eW = wrQ.pop_front();
            chk("R4 write address", memAddr, eW[63:32]);
            chk("R4 write data", memWdata, eW[31:0]);
          end
        end else begin
          if (rdQ.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R10 unexpected read actual=%h expected=none", memAddr);
          end else begin
            eR = rdQ.pop_front();
            chk("R2 read address", memAddr, eR);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doPtr(input logic [31:0] v);
    @(negedge clk); ptrWr = 1; ptrWrData = v;
    @(negedge clk); ptrWr = 0;
  endtask

  task automatic startFrame(input bit acc);
    @(negedge clk); frmStart = 1; addrAccept = acc;
    @(negedge clk); frmStart = 0; addrAccept = 0;
  endtask

  task automatic doFull();
    @(negedge clk); bufFull = 1; @(negedge clk); bufFull = 0;
  endtask

  task automatic doEnd();
    @(negedge clk); frmEnd = 1; @(negedge clk); frmEnd = 0;
  endtask

  task automatic doErr();
    @(negedge clk); frmErr = 1; @(negedge clk); frmErr = 0;
  endtask

  task automatic doClr();
    @(negedge clk); bnaClr = 1; @(negedge clk); bnaClr = 0;
  endtask

  task automatic doRd();
    @(negedge clk); errCntRd = 1; @(negedge clk); errCntRd = 0;
  endtask

  task automatic initList(input logic [31:0] base, input int n, input int wrapAt);
    for (int i = 0; i < n; i++) begin
      mem[wi(base) + 2 * i]     = bufA(i) | ((i == wrapAt) ? 32'h2 : 32'h0);
      mem[wi(base) + 2 * i + 1] = 32'h0;
    end
  endtask

  // Expected write-back pair, index step, then the following fetch
  task automatic expComplete(input bit sof, input bit eof);
    logic [31:0] p;
    p = mPtr();
    wrQ.push_back({p, mem[wi(p)] | 32'h1});
    wrQ.push_back({p + 32'd4, {30'd0, eof, sof}});
    if (mem[wi(p)][1] || mIdx == 1023) mIdx = 0;
    else mIdx++;
    rdQ.push_back(mPtr());
  endtask

  task automatic frameOk(input int nb);
    startFrame(1);
    for (int b = 0; b < nb; b++) begin
      expComplete(b == 0, b == nb - 1);
      if (b == nb - 1) doEnd();
      else doFull();
      tick(6);
    end
  endtask

  initial begin
    rstN = 0; rxEn = 0; ptrWr = 0; ptrWrData = 0; bnaClr = 0; errCntRd = 0;
    frmStart = 0; addrAccept = 0; bufFull = 0; frmEnd = 0; frmErr = 0;
    mBase = 0; mIdx = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    tick(3);
    rstN = 1;
    tick(4);
    chk("reset qPtr", qPtr, 32'h0);
    chk("reset bufValid", 32'(bufValid), 32'h0);
    chk("reset bnaFlag", 32'(bnaFlag), 32'h0);
    chk("reset errCnt", 32'(errCnt), 32'h0);
    chk("R10 no access while disabled", 32'(memReq), 32'h0);

    // R1 base load with low bits forced to zero
    initList(32'h400, 16, 5);
    doPtr(32'h0000_0405);
    mBase = 32'h400; mIdx = 0;
    tick(1);
    chk("R1 base alignment", qPtr, 32'h400);

    // R2 first fetch on enable
    rdQ.push_back(mPtr());
    rxEn = 1;
    tick(4);
    chk("R2 bufValid", 32'(bufValid), 32'h1);
    chk("R2 bufAddr", bufAddr, bufA(0));

    // R1 write while enabled is ignored
    doPtr(32'h800);
    tick(1);
    chk("R1 ignored while enabled", qPtr, 32'h400);

    // R3 rejected frame
    startFrame(0);
    tick(4);
    chk("R3 rejected frame keeps qPtr", qPtr, 32'h400);
    chk("R3 rejected frame keeps buffer", 32'(bufValid), 32'h1);

    // R4/R5 single-buffer frame
    frameOk(1);
    chk("R4 word0 used", mem[wi(32'h400)], bufA(0) | 32'h1);
    chk("R4 word1 sof+eof", mem[wi(32'h404)], 32'h3);
    chk("R5 step", qPtr, 32'h408);

    // R4 three-buffer frame
    frameOk(3);
    chk("R4 first word1 sof", mem[wi(32'h40C)], 32'h1);
    chk("R4 middle word1", mem[wi(32'h414)], 32'h0);
    chk("R4 last word1 eof", mem[wi(32'h41C)], 32'h2);
    chk("R5 step after 3", qPtr, 32'h420);

    // R5 wrap flag on entry 5, then R7 entry 0 still owned
    frameOk(2);
    chk("R5 wrap to base", qPtr, 32'h400);
    chk("R7 bnaFlag set", 32'(bnaFlag), 32'h1);
    chk("R7 irq pulse", 32'(irqSeen), 32'd1);
    chk("R7 no buffer", 32'(bufValid), 32'h0);
    chk("R7 no drop when idle", 32'(errCnt), 32'h0);
    doClr();
    tick(1);
    chk("R7 clear", 32'(bnaFlag), 32'h0);

    // R8 retry finds entry still owned: drop
    rdQ.push_back(mPtr());
    startFrame(1);
    tick(4);
    chk("R8 errCnt after drop", 32'(errCnt), 32'd1);
    chk("R8 frameDrop pulse", 32'(dropSeen), 32'd1);
    chk("R7 bnaFlag again", 32'(bnaFlag), 32'h1);

    // R8 software frees entries, retry proceeds
    for (int i = 0; i < 6; i++) mem[wi(32'h400) + 2 * i][0] = 1'b0;
    rdQ.push_back(mPtr());
    startFrame(1);
    tick(4);
    chk("R8 retry buffer", bufAddr, bufA(0));
    chk("R8 retry bufValid", 32'(bufValid), 32'h1);
    expComplete(1, 1);
    doEnd();
    tick(6);
    chk("R5 after retry frame", qPtr, 32'h408);

    // R6 error after one finished buffer
    startFrame(1);
    expComplete(1, 0);
    doFull();
    tick(6);
    rdQ.push_back(mPtr());
    doErr();
    tick(6);
    chk("R6 qPtr stays", qPtr, 32'h410);
    chk("R6 current not marked", 32'(mem[wi(32'h410)][0]), 32'h0);
    chk("R6 previous kept", mem[wi(32'h408)], bufA(1) | 32'h1);
    chk("R6 previous word1", mem[wi(32'h40C)], 32'h1);
    chk("R6 refetched buffer", bufAddr, bufA(2));

    // R8 owned entry met mid-frame
    mem[wi(32'h418)][0] = 1'b1;
    startFrame(1);
    expComplete(1, 0);
    doFull();
    tick(6);
    chk("R8 mid-frame drop count", 32'(errCnt), 32'd2);
    chk("R8 mid-frame no buffer", 32'(bufValid), 32'h0);
    chk("R8 mid-frame qPtr", qPtr, 32'h418);
    chk("R6 completed buffer kept", 32'(mem[wi(32'h410)][0]), 32'h1);

    // R9 clear on read and saturation
    doRd();
    chk("R9 read clears", 32'(errCnt), 32'h0);
    for (int k = 0; k < 260; k++) begin
      rdQ.push_back(mPtr());
      startFrame(1);
      tick(3);
    end
    chk("R9 saturate", 32'(errCnt), 32'd255);
    doRd();
    chk("R9 read clears after saturate", 32'(errCnt), 32'h0);

    // R5 hard limit of 1024 entries without wrap flags
    rxEn = 0;
    tick(2);
    doPtr(32'h1000);
    mBase = 32'h1000; mIdx = 0;
    initList(32'h1000, 1024, -1);
    doClr();
    tick(3);
    chk("R10 disabled after base load", 32'(memReq), 32'h0);
    rdQ.push_back(mPtr());
    rxEn = 1;
    tick(4);
    for (int f = 0; f < 1024; f++) frameOk(1);
    chk("R5 limit wrap qPtr", qPtr, 32'h1000);
    chk("R5 limit wrap hits owned entry", 32'(bnaFlag), 32'h1);
    chk("R4 entry 1023 word1", mem[wi(32'h1000) + 2047], 32'h3);

    tick(4);
    chk("R2 all reads seen", 32'(rdQ.size()), 32'h0);
    chk("R4 all writes seen", 32'(wrQ.size()), 32'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule